// File: doc/BRIEF.md
# Interrupt Routing Matrix

This block steers interrupt requests from nine on-chip peripheral sources onto eight request lines of a downstream interrupt controller. The sources are two serial ports, a parallel port, a floppy controller, the first disk channel and four shared bus interrupt pins (A to D). Each source owns a 4-bit routing field that names its target line. A trigger byte tells the controller, line by line, whether that line is level or edge sensitive. When several sources point at one line, that line is the OR of them. A routing value of zero, the cascade line 2, or any value from 8 to 15 leaves the source disconnected.

Software programs the block through three 32-bit configuration words. Each word is written whole, at a dword-aligned byte offset. The request lines are registered, so each output is one clock behind its sources. The trigger vector comes straight from the stored configuration.

Top module: `irq_route_matrix`

## Requirements
- R1: While reset is asserted, and on the first edge after it, all three configuration words are zero, `irq_req` is 0x00, `irq_trig` is 0x00, and every read returns zero.
- R2: A write with `reg_wr` high to byte offset 0x64, 0x68 or 0x6C stores the 32-bit word, and a read at that offset returns it exactly. A write to any other offset, including an offset that is not a multiple of four, changes nothing, and a read there returns zero.
- R3: `irq_trig` equals bits [31:24] of the word at 0x64. Bit i set to 1 marks line i as level triggered, and 0 marks it as edge triggered.
- R4: In the word at 0x68, bits [11:8] route serial port 1 (`src_req[0]`) and bits [15:12] route serial port 2 (`src_req[1]`).
- R5: In the word at 0x68, bits [19:16] route the parallel port (`src_req[2]`) and bits [23:20] route the floppy controller (`src_req[3]`).
- R6: In the word at 0x68, bits [27:24] route the first disk channel (`src_req[4]`). Bits [31:28] are stored but affect no line.
- R7: In the word at 0x6C, bits [3:0], [7:4], [11:8] and [15:12] route bus interrupts A, B, C and D (`src_req[5]` to `src_req[8]`).
- R8: A routing value of 0, 2, or 8 to 15 disconnects its source. Lines 0 and 2 never assert.
- R9: A line is high when any connected source routed to it is high.
- R10: `irq_req` is registered. The value seen after a clock edge is computed from the `src_req` and configuration present just before that edge. A configuration write therefore affects the lines one edge after the write's own edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte offset for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| src_req | input | 9 | Peripheral requests, bit order per R4 to R7 |
| irq_req | output | 8 | Routed request lines to the interrupt controller |
| irq_trig | output | 8 | Per-line trigger mode, 1 = level |

## Verification
A configuration write that moves a source and a rising request from that same source can land on the same clock edge. The bench provokes this by pointing serial port 1 at line 3, then raising its request while writing a new route to line 5 in the same cycle. The bench judges the result edge by edge. Just before the edge the line must still be low. Right after the edge line 3 must be high, because the old route was in use. One edge later line 5 must be high and line 3 low.

// File: rtl/irqrt_pkg.sv
package irqrt_pkg;

   // source indices as seen on src_req
   typedef enum int {
      SRC_SER_A  = 0,
      SRC_SER_B  = 1,
      SRC_PAR    = 2,
      SRC_FLOP   = 3,
      SRC_DISK   = 4,
      SRC_BUS_A  = 5,
      SRC_BUS_B  = 6,
      SRC_BUS_C  = 7,
      SRC_BUS_D  = 8
   } src_id_e;

   localparam int SRC_TOTAL = 9;

   // bit position of the trigger byte inside the flattened configuration
   localparam int TRIG_LSB = 24;

   // bit position of each source's routing field inside the flattened
   // configuration {word2, word1, word0}
   function automatic int field_lsb(input int src);
      case (src)
         SRC_SER_A: return 40;
         SRC_SER_B: return 44;
         SRC_PAR:   return 48;
         SRC_FLOP:  return 52;
         SRC_DISK:  return 56;
         SRC_BUS_A: return 64;
         SRC_BUS_B: return 68;
         SRC_BUS_C: return 72;
         default:   return 76;
      endcase
   endfunction

endpackage

// File: rtl/irqrt_cfg_regs.sv
module irqrt_cfg_regs #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 3,
   parameter int BASE_ADDR = 'h64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DATA_W-1:0]           wdata,
   output logic [DATA_W-1:0]           rdata,
   output logic [NUM_WORDS*DATA_W-1:0] cfg_flat
);

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int OFS_W      = $clog2(WORD_BYTES);
   localparam int IDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

   logic [ADDR_W-1:0] rel;
   logic [ADDR_W-1:0] word_no;
   logic [IDX_W-1:0]  idx;
   logic              hit;

   assign rel     = addr - ADDR_W'(BASE_ADDR);
   assign word_no = rel >> OFS_W;
   assign idx     = word_no[IDX_W-1:0];
   assign hit     = (addr >= ADDR_W'(BASE_ADDR))
                 && (rel[OFS_W-1:0] == '0)
                 && (word_no < ADDR_W'(NUM_WORDS));

   logic [DATA_W-1:0] words [NUM_WORDS];

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            words[w] <= '0;
         else if (wr_en && hit && (idx == IDX_W'(w)))
            words[w] <= wdata;
      end
      assign cfg_flat[w*DATA_W +: DATA_W] = words[w];
   end

   always_comb begin
      rdata = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (hit && (idx == IDX_W'(w)))
            rdata = words[w];
      end
   end

endmodule

// File: rtl/irqrt_field_map.sv
module irqrt_field_map #(
   parameter int CFG_W   = 96,
   parameter int NUM_SRC = 9,
   parameter int FIELD_W = 4
) (
   input  logic [CFG_W-1:0]   cfg_flat,
   output logic [FIELD_W-1:0] route [NUM_SRC]
);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam int LSB = irqrt_pkg::field_lsb(s);
      if (LSB + FIELD_W > CFG_W) begin : g_bad
         $error("routing field of a source lies outside the configuration");
      end
      assign route[s] = cfg_flat[LSB +: FIELD_W];
   end

   // bits with no routing meaning are read back only
   logic unused_cfg;
   assign unused_cfg = ^cfg_flat;

endmodule

// File: rtl/irqrt_line_merge.sv
module irqrt_line_merge #(
   parameter int NUM_SRC      = 9,
   parameter int NUM_LINES    = 8,
   parameter int FIELD_W      = 4,
   parameter int CASCADE_LINE = 2
) (
   input  logic [NUM_SRC-1:0]   src_req,
   input  logic [FIELD_W-1:0]   route [NUM_SRC],
   output logic [NUM_LINES-1:0] line_or
);

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      if (l == 0 || l == CASCADE_LINE) begin : g_dead
         // value 0 means "not connected"; the cascade line is reserved
         assign line_or[l] = 1'b0;
      end else begin : g_live
         logic [NUM_SRC-1:0] sel;
         for (genvar s = 0; s < NUM_SRC; s++) begin : g_tap
            assign sel[s] = src_req[s] && (route[s] == FIELD_W'(l));
         end
         assign line_or[l] = |sel;
      end
   end

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int NUM_WORDS    = 3,
   parameter int BASE_ADDR    = 'h64,
   parameter int NUM_SRC      = 9,
   parameter int NUM_LINES    = 8,
   parameter int FIELD_W      = 4,
   parameter int CASCADE_LINE = 2,
   parameter bit REG_OUT      = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [NUM_SRC-1:0]   src_req,
   output logic [NUM_LINES-1:0] irq_req,
   output logic [NUM_LINES-1:0] irq_trig
);

   localparam int CFG_W = NUM_WORDS * DATA_W;

   // elaboration checks
   if (DATA_W != 32) begin : g_chk_dw
      $error("configuration words must be 32 bits");
   end
   if (NUM_SRC != irqrt_pkg::SRC_TOTAL) begin : g_chk_src
      $error("source count does not match the field layout");
   end
   if (NUM_LINES > (1 << FIELD_W)) begin : g_chk_lines
      $error("routing field too narrow for the line count");
   end
   if (NUM_WORDS < 3) begin : g_chk_words
      $error("layout needs three configuration words");
   end
   if ((BASE_ADDR % (DATA_W / 8)) != 0) begin : g_chk_base
      $error("base offset must be word aligned");
   end
   if (CASCADE_LINE >= NUM_LINES) begin : g_chk_casc
      $error("cascade line outside the line range");
   end

   logic [CFG_W-1:0]     cfg_flat;
   logic [FIELD_W-1:0]   route [NUM_SRC];
   logic [NUM_LINES-1:0] line_or;

   irqrt_cfg_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NUM_WORDS (NUM_WORDS),
      .BASE_ADDR (BASE_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .cfg_flat (cfg_flat)
   );

   irqrt_field_map #(
      .CFG_W   (CFG_W),
      .NUM_SRC (NUM_SRC),
      .FIELD_W (FIELD_W)
   ) u_map (
      .cfg_flat (cfg_flat),
      .route    (route)
   );

   irqrt_line_merge #(
      .NUM_SRC      (NUM_SRC),
      .NUM_LINES    (NUM_LINES),
      .FIELD_W      (FIELD_W),
      .CASCADE_LINE (CASCADE_LINE)
   ) u_merge (
      .src_req (src_req),
      .route   (route),
      .line_or (line_or)
   );

   assign irq_trig = cfg_flat[irqrt_pkg::TRIG_LSB +: NUM_LINES];

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n)
            irq_req <= '0;
         else
            irq_req <= line_or;
      end
   end else begin : g_comb_out
      assign irq_req = line_or;
   end

endmodule

// File: rtl/irq_route_matrix_chk.sv
module irq_route_matrix_chk #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int NUM_WORDS    = 3,
   parameter int BASE_ADDR    = 'h64,
   parameter int NUM_SRC      = 9,
   parameter int NUM_LINES    = 8,
   parameter int CASCADE_LINE = 2,
   parameter bit REG_OUT      = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic                 reg_wr,
   input logic [DATA_W-1:0]    reg_wdata,
   input logic [DATA_W-1:0]    reg_rdata,
   input logic [NUM_SRC-1:0]   src_req,
   input logic [NUM_LINES-1:0] irq_req,
   input logic [NUM_LINES-1:0] irq_trig
);

   localparam int LAST_ADDR = BASE_ADDR + (NUM_WORDS - 1) * (DATA_W / 8);

   logic mapped;
   always_comb begin
      mapped = 1'b0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (reg_addr == ADDR_W'(BASE_ADDR + w * (DATA_W / 8)))
            mapped = 1'b1;
      end
   end

   logic unused_chk;
   assign unused_chk = ^{src_req, reg_wdata[DATA_W-1:0]} ^ (LAST_ADDR > 0);

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (irq_req == '0 && irq_trig == '0));

   assert_trig_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(BASE_ADDR))
      |=> irq_trig == $past(reg_wdata[31:24]));

   assert_stray_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !mapped) |=> $stable(irq_trig));

   assert_stray_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> reg_rdata == '0);

   assert_dead_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr || !reg_wr |-> (irq_req[0] == 1'b0 && irq_req[CASCADE_LINE] == 1'b0));

   if (REG_OUT) begin : g_lat
      assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (src_req == '0) |=> irq_req == '0);
   end

endmodule

bind irq_route_matrix irq_route_matrix_chk #(
   .ADDR_W       (ADDR_W),
   .DATA_W       (DATA_W),
   .NUM_WORDS    (NUM_WORDS),
   .BASE_ADDR    (BASE_ADDR),
   .NUM_SRC      (NUM_SRC),
   .NUM_LINES    (NUM_LINES),
   .CASCADE_LINE (CASCADE_LINE),
   .REG_OUT      (REG_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .src_req   (src_req),
   .irq_req   (irq_req),
   .irq_trig  (irq_trig)
);

// File: tb/irq_route_matrix_test.sv
`timescale 1ns/1ps
module irq_route_matrix_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [8:0]  src_req = '0;
   logic [7:0]  irq_req;
   logic [7:0]  irq_trig;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   irq_route_matrix uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .src_req   (src_req),
      .irq_req   (irq_req),
      .irq_trig  (irq_trig)
   );

   // {word 0x68, word 0x6C, src_req, expected irq_req}
   localparam int NVEC = 14;
   localparam logic [80:0] VEC [NVEC] = '{
      {32'h07654300, 32'h00001000, 9'h001, 8'h08},
      {32'h07654300, 32'h00001000, 9'h002, 8'h10},
      {32'h07654300, 32'h00001000, 9'h004, 8'h20},
      {32'h07654300, 32'h00001000, 9'h008, 8'h40},
      {32'h07654300, 32'h00001000, 9'h010, 8'h80},
      {32'h07654300, 32'h00001000, 9'h100, 8'h02},
      {32'h07654300, 32'h00001000, 9'h0E0, 8'h00},
      {32'h07654300, 32'h00001000, 9'h1FF, 8'hFA},
      {32'h00003300, 32'h00000000, 9'h002, 8'h08},
      {32'hF0000000, 32'h00000000, 9'h010, 8'h00},
      {32'h00000000, 32'h00004321, 9'h060, 8'h02},
      {32'h00000000, 32'h00004321, 9'h180, 8'h18},
      {32'h0F092800, 32'h00000000, 9'h01F, 8'h00},
      {32'h01000000, 32'h00000001, 9'h030, 8'h02}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: state during reset
      check("R1 irq_req", {24'h0, irq_req}, 32'h0);
      check("R1 irq_trig", {24'h0, irq_trig}, 32'h0);
      rd_check("R1 word64", 8'h64, 32'h0);
      rd_check("R1 word68", 8'h68, 32'h0);
      rd_check("R1 word6C", 8'h6C, 32'h0);
      rst_n = 1'b1;

      // R2 and R3: readback and trigger byte
      wr_word(8'h64, 32'h82000000);
      rd_check("R2 readback 64", 8'h64, 32'h82000000);
      check("R3 trigger vector", {24'h0, irq_trig}, 32'h82);
      wr_word(8'h6C, 32'hA5C30F1E);
      rd_check("R2 readback 6C", 8'h6C, 32'hA5C30F1E);
      wr_word(8'h66, 32'hFFFFFFFF);
      check("R2 unaligned write ignored", {24'h0, irq_trig}, 32'h82);
      rd_check("R2 unaligned read", 8'h66, 32'h0);
      rd_check("R2 word64 intact", 8'h64, 32'h82000000);
      wr_word(8'h70, 32'h12345678);
      rd_check("R2 out of range read", 8'h70, 32'h0);
      wr_word(8'h60, 32'h12345678);
      check("R2 below range write ignored", {24'h0, irq_trig}, 32'h82);

      // table walk: R4/R5/R6/R7/R8/R9
      for (int i = 0; i < NVEC; i++) begin
         wr_word(8'h68, VEC[i][80:49]);
         wr_word(8'h6C, VEC[i][48:17]);
         src_req = VEC[i][16:8];
         @(negedge clk);
         check($sformatf("R4/R5/R6/R7/R8/R9 vector %0d", i),
               {24'h0, irq_req}, {24'h0, VEC[i][7:0]});
         src_req = '0;
         @(negedge clk);
      end
      check("R10 lines drop after sources idle", {24'h0, irq_req}, 32'h0);

      // R10: route write and request rise on the same edge
      wr_word(8'h68, 32'h00000300);
      wr_word(8'h6C, 32'h00000000);
      @(negedge clk);
      reg_addr  = 8'h68;
      reg_wdata = 32'h00000500;
      reg_wr    = 1'b1;
      src_req   = 9'h001;
      #1;
      check("R10 no change before edge", {24'h0, irq_req}, 32'h0);
      @(negedge clk);
      reg_wr = 1'b0;
      check("R10 old route used on write edge", {24'h0, irq_req}, 32'h08);
      @(negedge clk);
      check("R10 new route one edge later", {24'h0, irq_req}, 32'h20);

      // R1: reset in the middle of operation
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 lines cleared by reset", {24'h0, irq_req}, 32'h0);
      check("R1 trigger cleared by reset", {24'h0, irq_trig}, 32'h0);
      rd_check("R1 routing word cleared", 8'h68, 32'h0);
      src_req = '0;
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5.0 * 50000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule